// File: doc/BRIEF.md
# Error-Driven Clock-Gate and Supply-Voltage Request Controller

This controller sits beside a five-stage pipeline (fetch, decode, execute, memory, writeback) whose stage registers correct their own late-arriving data and flag when they have done so. It turns those flags into two controls: a global clock enable that freezes the whole pipeline, and a digital request code for the supply regulator. Each code step is 10 mV, so code 120 means 1.20 V and code 90 means 0.90 V.

Only the memory-stage flag matters. A late result in fetch, decode or execute is repaired by the next stage's spare slack, so those three flags are accepted but have no effect. This lets the supply sink past the point where execute-stage errors first appear. When the memory flag is seen while the pipeline is advancing, the clock is held off for exactly one cycle so that the corrected value can propagate, and the voltage request steps up at once. The request steps down only after a run of error-free advancing cycles. A latch-based gate also produces the gated pipeline clock from the enable.

Top module: `vscale_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, the voltage code equals the maximum (default 120), the clock enable is 1 and the stall indicator is 0.
- R2: A memory-stage flag that is high at a clock edge where the clock enable is 1 drives the clock enable to 0 and the stall indicator to 1 for exactly the following cycle. The enable returns to 1 at the next edge, even if the flag stays high.
- R3: At an edge where the clock enable is 0 (the stall cycle), the memory-stage flag is ignored. There is no new stall, the voltage code does not change, and the clean-cycle count is neither advanced nor cleared.
- R4: A memory-stage flag seen at an edge with the enable at 1 raises the voltage code by one at that same edge and clears the clean-cycle count.
- R5: The voltage code never exceeds the maximum (default 120). A flag seen at the maximum leaves the code unchanged.
- R6: Each edge where the enable is 1 and the memory flag is 0 counts as one clean cycle. On the 16th consecutive clean cycle (a parameter), the code drops by one and the count restarts from zero.
- R7: The voltage code never falls below the minimum (default 90). A 16th clean cycle at the minimum leaves the code unchanged.
- R8: The fetch, decode and execute error flags do not change the clock enable, the stall indicator or the voltage code.
- R9: The gated clock output is high during a clock high phase only if the enable was 1 during the low phase just before that phase.
- R10: The stall indicator is always the complement of the clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| err_fetch_i | input | 1 | Fetch-stage corrected-error flag (no effect) |
| err_decode_i | input | 1 | Decode-stage corrected-error flag (no effect) |
| err_exec_i | input | 1 | Execute-stage corrected-error flag (no effect) |
| err_mem_i | input | 1 | Memory-stage error flag |
| clk_en_o | output | 1 | Global pipeline clock enable |
| stall_o | output | 1 | High during the one-cycle pipeline suspension |
| vcode_o | output | 8 | Supply request code, 10 mV per step |
| gclk_o | output | 1 | Gated pipeline clock |

## Verification
The enable, stall and voltage code are registered, so a flag sampled at an edge shows up on these outputs right after that same edge. The bench sets its inputs on the falling edge, updates its reference model at the rising edge, and compares at the next falling edge. The gated clock is checked a short delay after each rising edge against the enable value the model held before that edge, because the latch closes at the rising edge. Downward steps come due on the 16th clean edge, and the model counts these edges itself. Stall edges are skipped by the model, just as R3 demands.

// File: rtl/vscale_pkg.sv
// Package: shared constants and helpers for the voltage-scaling controller.
// Assumes codes are unsigned, 10 mV per LSB.
package vscale_pkg;
    localparam int unsigned CODE_W = 8;
    typedef logic [CODE_W-1:0] vcode_t;

    // Next code on a raise request, saturating at the ceiling.
    function automatic vcode_t code_up(input vcode_t cur, input vcode_t ceil_v);
        return (cur >= ceil_v) ? ceil_v : vcode_t'(cur + 1'b1);
    endfunction

    // Next code on a lower request, saturating at the floor.
    function automatic vcode_t code_down(input vcode_t cur, input vcode_t floor_v);
        return (cur <= floor_v) ? floor_v : vcode_t'(cur - 1'b1);
    endfunction
endpackage

// File: rtl/vscale_stall_seq.sv
// Module: one-cycle stall sequencer.
// A memory error seen while the enable is high drops the enable for exactly one cycle.
// Assumes the error flag is stale (pipeline frozen) while the enable is low.
module vscale_stall_seq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic err_mem_i,
    output logic en_o,
    output logic hit_o
);
    logic en_q;

    // A qualified hit is an error seen on an advancing cycle.
    assign hit_o = err_mem_i & en_q;

    // Enable register: low for one cycle after a qualified hit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= ~hit_o;
    end

    assign en_o = en_q;
endmodule

// File: rtl/vscale_code_step.sv
// Module: voltage code stepper with a clean-run counter.
// Raises the code immediately on a hit. Lowers it after QUIET consecutive clean advancing cycles.
// Assumes VMIN <= VMAX and QUIET >= 1.
module vscale_code_step #(
    parameter int unsigned VMIN  = 90,
    parameter int unsigned VMAX  = 120,
    parameter int unsigned QUIET = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   adv_i,
    input  logic                   hit_i,
    output vscale_pkg::vcode_t     code_o
);
    import vscale_pkg::*;
    localparam int unsigned CNT_W  = $clog2(QUIET + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET - 1);
    localparam vcode_t CEIL  = vcode_t'(VMAX);
    localparam vcode_t FLOOR = vcode_t'(VMIN);

    vcode_t           code_q;
    logic [CNT_W-1:0] cnt_q;

    // Code and clean-run counter update. Both hold on a stall cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            code_q <= CEIL;
            cnt_q  <= '0;
        end else if (adv_i) begin
            if (hit_i) begin
                code_q <= code_up(code_q, CEIL);
                cnt_q  <= '0;
            end else if (cnt_q == LAST) begin
                code_q <= code_down(code_q, FLOOR);
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/vscale_clk_gate.sv
// Module: latch-based glitch-free clock gate.
// The latch is transparent while the clock is low, so the enable is frozen during the high phase.
module vscale_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // Enable latch, open during the low phase.
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/vscale_ctrl.sv
// Module: top of the error-driven clock-gate and voltage request controller.
// Only the memory-stage flag drives the policy. The other stage flags are accepted and unused,
// because those stages correct themselves.
module vscale_ctrl #(
    parameter int unsigned VMIN  = 90,
    parameter int unsigned VMAX  = 120,
    parameter int unsigned QUIET = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       err_fetch_i,
    input  logic       err_decode_i,
    input  logic       err_exec_i,
    input  logic       err_mem_i,
    output logic       clk_en_o,
    output logic       stall_o,
    output logic [7:0] vcode_o,
    output logic       gclk_o
);
    logic en, hit;
    logic unused_flags;

    // Early-stage flags are deliberately unused.
    assign unused_flags = err_fetch_i ^ err_decode_i ^ err_exec_i;

    vscale_stall_seq u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .err_mem_i(err_mem_i),
        .en_o(en), .hit_o(hit)
    );

    vscale_code_step #(.VMIN(VMIN), .VMAX(VMAX), .QUIET(QUIET)) u_step (
        .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(en), .hit_i(hit),
        .code_o(vcode_o)
    );

    vscale_clk_gate u_gate (.clk_i(clk_i), .en_i(en), .gclk_o(gclk_o));

    assign clk_en_o = en;
    assign stall_o  = ~en;
endmodule

// File: rtl/vscale_ctrl_chk.sv
// Module: assertion checker bound to vscale_ctrl. It observes ports only.
module vscale_ctrl_chk #(
    parameter int unsigned VMIN = 90,
    parameter int unsigned VMAX = 120
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       err_mem_i,
    input logic       clk_en_o,
    input logic       stall_o,
    input logic [7:0] vcode_o
);
    assert_gate_on_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_mem_i && clk_en_o) |=> !clk_en_o);
    assert_single_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clk_en_o |=> clk_en_o);
    assert_hold_in_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clk_en_o |=> $stable(vcode_o));
    assert_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_mem_i && clk_en_o && vcode_o < 8'(VMAX)) |=> (vcode_o == $past(vcode_o) + 8'd1));
    assert_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vcode_o <= 8'(VMAX));
    assert_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vcode_o >= 8'(VMIN));
    assert_stall_compl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o != clk_en_o);
endmodule

bind vscale_ctrl vscale_ctrl_chk #(.VMIN(VMIN), .VMAX(VMAX)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_mem_i(err_mem_i),
    .clk_en_o(clk_en_o), .stall_o(stall_o), .vcode_o(vcode_o)
);

// File: tb/vscale_ctrl_tb.sv
// Bench: behavioural reference model compared on every clock.
module vscale_ctrl_tb_top;
    localparam int VMIN = 90, VMAX = 120, QUIET = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ef = 0, ed = 0, ee = 0, em = 0;
    logic clk_en, stall, gclk;
    logic [7:0] vcode;
    int checks = 0, fails = 0;
    int m_code = VMAX, m_q = 0, m_en = 1, prev_en = 1;
    bit done = 0;

    always #4 clk = ~clk;

    vscale_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .err_fetch_i(ef), .err_decode_i(ed),
        .err_exec_i(ee), .err_mem_i(em), .clk_en_o(clk_en), .stall_o(stall),
        .vcode_o(vcode), .gclk_o(gclk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, check the gate, then check the outputs.
    task automatic step(input string tag);
        @(posedge clk);
        prev_en = m_en;
        if (m_en == 0) m_en = 1;
        else if (em) begin
            m_en = 0; m_q = 0;
            if (m_code < VMAX) m_code++;
        end else if (m_q == QUIET - 1) begin
            m_q = 0;
            if (m_code > VMIN) m_code--;
        end else m_q++;
        #2;
        chk("R9 gclk", int'(gclk), prev_en);
        @(negedge clk);
        chk({tag, " clk_en"}, int'(clk_en), m_en);
        chk("R10 stall", int'(stall), 1 - m_en);
        chk({tag, " vcode"}, int'(vcode), m_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 vcode", int'(vcode), VMAX);
        chk("R1 clk_en", int'(clk_en), 1);
        chk("R1 stall", int'(stall), 0);
        rst_n = 1'b1;
        // R6: clean run steps down on the 16th edge.
        for (int i = 0; i < 20; i++) step("R6");
        chk("R6 one step down", int'(vcode), VMAX - 1);
        // R8: early-stage flags toggle with no effect.
        for (int i = 0; i < 40; i++) begin
            ef = i[0]; ed = i[1]; ee = i[2];
            step("R8");
        end
        ef = 0; ed = 0; ee = 0;
        // R2/R4: a single memory error pulse.
        em = 1; step("R4");
        em = 0; step("R2");
        step("R2");
        // R3: flag held high, so stall edges ignore it.
        em = 1; ee = 1;
        for (int i = 0; i < 6; i++) step("R3");
        em = 0; ee = 0;
        // R7: long clean run reaches the floor.
        for (int i = 0; i < 700; i++) step("R7");
        chk("R7 floor", int'(vcode), VMIN);
        // R5: sustained error saturates at the ceiling.
        em = 1;
        for (int i = 0; i < 80; i++) step("R5");
        chk("R5 ceiling", int'(vcode), VMAX);
        em = 0;
        for (int i = 0; i < 4; i++) step("R2");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule